// File: doc/BRIEF.md
# Auto-Indexed Power Level Table

This block keeps eight byte-wide power-amplifier control settings. A serial host reaches all of them through one access point. There is no address on the port. A hidden index chooses the entry, and it moves forward by one after every byte that is accepted. Once the host deasserts chip select, the index returns to entry 0.

An access opens with a start strobe that also picks one of two modes. Single mode moves one byte. Burst mode streams consecutive entries and wraps from the last entry back to the first.

The transmitter side does not use the index. A 3-bit selector picks one entry, and a registered output carries that entry's value to the power amplifier. A sleep pulse clears entries 1 to 7. Entry 0 keeps its value, so the transmitter always has a known setting after wake-up.

Top module: `pwr_level_table`

## Requirements
- R1: Reset sets entry 0 to parameter DEFAULT0 (8'hC6 by default) and entries 1 to 7 to 8'h00. During reset `rd_data_o` and `pa_level_o` read 8'h00.
- R2: The index starts at 0. Each accepted byte read or write moves it up by one, and it wraps from 7 to 0.
- R3: While `cs_n_i` is high, the index is held at 0, any open access is closed, and read and write strobes have no effect.
- R4: A start strobe while `cs_n_i` is low opens an access. With `burst_i`=1 it accepts bytes until `cs_n_i` goes high. With `burst_i`=0 it accepts exactly one byte, and later strobes are ignored until the next start. A read or write strobe in the same cycle as a start strobe is ignored.
- R5: An accepted write stores `wr_data_i` into the entry at the index.
- R6: After an accepted read, `rd_data_o` shows the entry at the index on the next cycle. Otherwise `rd_data_o` holds its value. A read that follows a write in the same chip-select window therefore returns the next entry.
- R7: A read and a write strobe in the same accepted cycle perform only the write. `rd_data_o` holds its value and the index advances once.
- R8: A `sleep_i` pulse clears entries 1 to 7 to 8'h00 and leaves entry 0 unchanged. A write to entries 1 to 7 in the same cycle is lost, while a write to entry 0 in the same cycle takes effect.
- R9: `pa_level_o` equals the entry chosen by `pa_sel_i` as it stood one cycle earlier. It therefore follows a selector change or an entry change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip-select level, high means deselected |
| start_i | input | 1 | Access start strobe |
| burst_i | input | 1 | Mode taken at start: 1 burst, 0 single byte |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Write data |
| rd_i | input | 1 | Byte read strobe |
| rd_data_o | output | 8 | Registered read data |
| sleep_i | input | 1 | Sleep entry pulse |
| pa_sel_i | input | 3 | Transmitter entry selector |
| pa_level_o | output | 8 | Registered transmitter setting |

## Verification
Two situations are hard to reach from the ports. The first is a sleep pulse in the same cycle as an accepted write. The second is reading back a byte just written, since the hidden index has already moved past it. The stimulus writes entry 0 during a sleep pulse, then writes entry 1 during a second pulse. It then toggles chip select and bursts through all entries to show which bytes survived. Burst runs of more than eight bytes push the index across its wrap point. Extra strobes after a single access, and strobes in the start cycle, show up as unchanged entries in a later read-back.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2
  } acc_e;
endpackage

// File: rtl/ptab_index.sv
module ptab_index
  import ptab_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             start_i,
  input  logic             burst_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [IDX_W-1:0] idx_o,
  output acc_e             acc_o
);
  logic [IDX_W-1:0] idx_q;
  logic             armed_q, burst_q;
  logic [IDX_W-1:0] idx_inc;

  assign idx_inc = (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;

  always_comb begin
    acc_o = ACC_NONE;
    if (!cs_n_i && armed_q && !start_i) begin
      if (wr_i)      acc_o = ACC_WR;
      else if (rd_i) acc_o = ACC_RD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
      burst_q <= 1'b0;
    end else if (cs_n_i) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      burst_q <= burst_i;
    end else if (acc_o != ACC_NONE) begin
      idx_q <= idx_inc;
      if (!burst_q) armed_q <= 1'b0;
    end
  end

  assign idx_o = idx_q;

  // R3: deselect parks the index at 0
  a_r3_cs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> idx_q == '0);
  // R2: accepted byte steps the index with wrap
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != ACC_NONE) |=>
      idx_q == (($past(idx_q) == IDX_W'(DEPTH - 1)) ? '0 : $past(idx_q) + 1'b1));
  // R4: single access closes after one byte
  a_r4_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != ACC_NONE && !burst_q) |=> !armed_q);
  // R3: nothing accepted while deselected
  a_r3_no_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> acc_o == ACC_NONE);
endmodule

// File: rtl/ptab_store.sv
module ptab_store
  import ptab_pkg::*;
#(
  parameter int              DEPTH    = 8,
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEFAULT0 = 8'hC6,
  localparam int             IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sleep_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] sel_entry_o
);
  logic [DATA_W-1:0] tab_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic we;
    assign we = (acc_i == ACC_WR) && (idx_i == IDX_W'(k));
    if (k == 0) begin : g_keep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  tab_q[k] <= DEFAULT0;
        else if (we)  tab_q[k] <= wr_data_i;
      end
      // R8: entry 0 survives sleep
      a_r8_keep0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_i && !we) |=> $stable(tab_q[k]));
    end else begin : g_vol
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       tab_q[k] <= '0;
        else if (sleep_i)  tab_q[k] <= '0;
        else if (we)       tab_q[k] <= wr_data_i;
      end
      // R8: upper entries cleared on sleep
      a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> tab_q[k] == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (acc_i == ACC_RD)   rd_q <= tab_q[idx_i];
  end

  assign rd_data_o   = rd_q;
  assign sel_entry_o = tab_q[sel_i];

  // R6: read returns the indexed entry next cycle
  a_r6_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_RD) |=> rd_q == $past(tab_q[idx_i]));
  // R7: no read data update without a read
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i != ACC_RD) |=> $stable(rd_q));
endmodule

// File: rtl/ptab_tx.sv
module ptab_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] entry_i,
  output logic [DATA_W-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else         level_o <= entry_i;
  end
endmodule

// File: rtl/pwr_level_table.sv
module pwr_level_table
  import ptab_pkg::*;
#(
  parameter int                DEPTH    = 8,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEFAULT0 = 8'hC6,
  localparam int               IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sleep_i,
  input  logic [IDX_W-1:0]  pa_sel_i,
  output logic [DATA_W-1:0] pa_level_o
);
  logic [IDX_W-1:0]  idx;
  acc_e              acc;
  logic [DATA_W-1:0] sel_entry;

  ptab_index #(.DEPTH(DEPTH)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs_n_i),
    .start_i (start_i),
    .burst_i (burst_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .idx_o   (idx),
    .acc_o   (acc)
  );

  ptab_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEFAULT0(DEFAULT0)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .idx_i       (idx),
    .wr_data_i   (wr_data_i),
    .sleep_i     (sleep_i),
    .sel_i       (pa_sel_i),
    .rd_data_o   (rd_data_o),
    .sel_entry_o (sel_entry)
  );

  ptab_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .entry_i (sel_entry),
    .level_o (pa_level_o)
  );

  // R9: transmitter output lags the selected entry by one cycle
  a_r9_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pa_level_o == $past(sel_entry));
  // R7: a combined strobe is taken as a write
  a_r7_wr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !cs_n_i) |-> acc != ACC_RD);
endmodule

// File: tb/pwr_level_table_bench.sv
module pwr_level_table_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n_i = 1'b1, start_i = 1'b0, burst_i = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, sleep_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] pa_sel_i = '0;
  logic [7:0] rd_data_o, pa_level_o;

  always #4 clk = ~clk;

  pwr_level_table u_pwr_level_table (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .start_i(start_i),
    .burst_i(burst_i), .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .sleep_i(sleep_i), .pa_sel_i(pa_sel_i),
    .pa_level_o(pa_level_o)
  );

  typedef struct {
    int         due;
    bit         is_pa;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // requirement model
  logic [7:0] mdl [8];
  int  m_idx = 0;
  bit  m_armed = 0, m_burst = 0;
  logic [7:0] m_rd = '0;
  bit  cs_v = 1'b1;
  logic [2:0] sel_v = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      if (q[0].is_pa) check(q[0].req, "pa_level_o", pa_level_o, q[0].exp);
      else            check(q[0].req, "rd_data_o", rd_data_o, q[0].exp);
      void'(q.pop_front());
    end
  end

  // driver: one cycle of stimulus plus expectations
  task automatic drive(bit start, bit burst, bit wr, bit rd, logic [7:0] d, bit slp);
    logic [7:0] pre [8];
    bit acc;
    item_t it;
    @(posedge clk); #1;
    cs_n_i = cs_v; pa_sel_i = sel_v; start_i = start; burst_i = burst;
    wr_i = wr; rd_i = rd; wr_data_i = d; sleep_i = slp;
    pre = mdl;
    acc = !cs_v && m_armed && !start && (wr || rd);
    it.due = cyc + 1; it.is_pa = 1'b1; it.exp = pre[sel_v];
    it.req = {"R9/", cur_req}; q.push_back(it);
    if (acc && rd && !wr) m_rd = pre[m_idx];
    it.is_pa = 1'b0; it.exp = m_rd; it.req = {"R6/", cur_req}; q.push_back(it);
    if (acc && wr) mdl[m_idx] = d;
    if (slp) for (int k = 1; k < 8; k++) mdl[k] = '0;
    if (cs_v) begin
      m_idx = 0; m_armed = 0;
    end else if (start) begin
      m_armed = 1; m_burst = burst;
    end else if (acc) begin
      m_idx = (m_idx + 1) % 8;
      if (!m_burst) m_armed = 0;
    end
  endtask

  task automatic idle();            drive(0, 0, 0, 0, 8'h00, 0); endtask
  task automatic wr(logic [7:0] d); drive(0, 0, 1, 0, d, 0);     endtask
  task automatic rd();              drive(0, 0, 0, 1, 8'h00, 0); endtask
  task automatic reopen(bit burst);
    cs_v = 1; idle(); cs_v = 0; drive(1, burst, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    mdl[0] = 8'hC6;
    for (int k = 1; k < 8; k++) mdl[k] = '0;
    #21;
    check("R1", "rd_data_o in reset", rd_data_o, 8'h00);
    check("R1", "pa_level_o in reset", pa_level_o, 8'h00);
    rst_ni = 1'b1;

    cur_req = "R1";
    sel_v = 3'd0; idle(); idle();
    sel_v = 3'd3; idle(); idle();

    cur_req = "R2_R5";           // burst write with wrap
    reopen(1);
    for (int k = 0; k < 8; k++) wr(8'h10 + 8'(k));
    wr(8'hA0); wr(8'hA1);
    reopen(1);
    for (int k = 0; k < 9; k++) rd();

    cur_req = "R4";              // single access, extra strobe ignored
    reopen(0); wr(8'h55); wr(8'h66);
    drive(1, 0, 0, 0, 8'h00, 0); rd();
    cur_req = "R3";
    reopen(1); rd(); rd();
    cs_v = 1; wr(8'h99); rd();   // strobes while deselected
    reopen(1); rd();

    cur_req = "R4";              // strobe in start cycle ignored
    cs_v = 1; idle(); cs_v = 0;
    drive(1, 1, 1, 0, 8'h77, 0); rd(); rd();

    cur_req = "R7";              // combined strobe
    reopen(1); rd();
    cs_v = 1; idle(); cs_v = 0; drive(1, 1, 0, 0, 8'h00, 0);
    drive(0, 0, 1, 1, 8'h33, 0); idle(); rd();
    reopen(1); rd();

    cur_req = "R9";
    sel_v = 3'd2; idle(); idle();
    reopen(1); rd(); rd(); wr(8'h5A); idle(); idle();
    sel_v = 3'd7; idle(); idle();

    cur_req = "R8";              // sleep races with writes
    reopen(1);
    drive(0, 0, 1, 0, 8'h44, 1);
    drive(0, 0, 1, 0, 8'hBB, 1);
    reopen(1);
    for (int k = 0; k < 8; k++) rd();
    sel_v = 3'd2; idle(); idle();
    sel_v = 3'd0; idle(); idle();
    cs_v = 1; idle(); idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule